// File: doc/BRIEF.md
# Serial Port Command and Status Register Block

This block is the register front end of a serial port. A host reaches it over a byte-wide bus with a 6-bit byte address, one access per cycle. It holds two mode registers that share one address, a status byte, an interrupt status and mask pair, and a packed command byte. A command byte carries three independent actions in separate fields: a miscellaneous action, a transmitter action and a receiver action.

On the transmit side it keeps a single holding byte. When the transmitter is enabled, the byte goes to a downstream serializer as a one-cycle valid pulse; the serializer is taken to be always ready. On the receive side, a deserializer pushes bytes into a small FIFO through a valid/ready pair, and the host pops the FIFO by reading the data offset. One level-sensitive interrupt line is the OR of the unmasked interrupt status bits. The two baud divider bytes are fixed by parameters and can only be read.

Top module: `uart_csr_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x08 (only transmitter-empty set). Both mode registers, the interrupt status and the mask read 0. irq, txValid and rxReady are low.
- R2: The mode address is 0x00. A write loads the mode register chosen by a pointer and then points it at the second mode register. A read returns the register the pointer currently selects. Miscellaneous code 1 points the pointer back at the first mode register.
- R3: A write to 0x08 is a command. Bits [5:4] are the miscellaneous field: 0 = none, 1 = pointer reset, 2 = receiver reset, 3 = transmitter reset. Bits [3:2] drive the transmitter and bits [1:0] the receiver, with 1 = enable, 2 = disable, and 0 or 3 = no change. Bits [7:6] are ignored. The miscellaneous action takes effect before the transmitter and receiver actions.
- R4: A write to 0x0C latches the byte. If the transmitter is enabled, txValid is high for the next cycle only, txData carries the byte, and transmitter-empty stays set. Otherwise transmitter-empty (status bit 3) clears and the byte is held.
- R5: Enabling the transmitter while a byte is held hands that byte off (a txValid pulse in the next cycle) and sets transmitter-empty.
- R6: Status bit 2 (transmitter ready) equals the transmitter enable.
- R7: A transmitter reset disables the transmitter, sets transmitter-empty and drops any held byte. A later enable produces no pulse.
- R8: rxReady is high when the receiver is enabled and the FIFO of RX_DEPTH bytes is not full. Accepted bytes are read back in arrival order at 0x0C. Status bit 0 is set when the FIFO holds any byte and bit 1 when it is full. Reading an empty FIFO returns 0.
- R9: A receiver reset disables the receiver and empties the FIFO.
- R10: The interrupt status reads at 0x14. Bit 0 equals transmitter ready. Bit 1 equals FIFO-full when bit 6 of the first mode register is set, and FIFO-not-empty when it is clear. All other bits read 0.
- R11: A write to 0x14 loads the interrupt mask. irq is high exactly when some interrupt status bit and its mask bit are both 1.
- R12: 0x18 and 0x1C return the BAUD_HI and BAUD_LO parameters. Writes to 0x04 and 0x10 change nothing. Reads of 0x08, 0x10 and any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from current state |
| txValid | output | 1 | One-cycle hand-off pulse to the serializer |
| txData | output | 8 | Byte being handed off |
| rxValid | input | 1 | Deserializer offers a byte |
| rxData | input | 8 | Offered byte |
| rxReady | output | 1 | Byte is accepted when high with rxValid |
| irq | output | 1 | Level interrupt |

## Verification
The command byte is swept over all 64 field combinations from six start states of transmitter, receiver and held byte, with bits 7:6 varied. This catches a decoder that applies the transmitter reset after an enable in the same byte, or one that forgets to hand off a held byte on enable. The mode pointer is walked through write, write, overwrite and pointer reset, which exposes a pointer that toggles instead of sticking on the second register. The FIFO is filled to full, offered one byte too many, and drained past empty, so lost order, an accepted overflow byte, or a nonzero read when empty all show up. The interrupt status and irq are swept against every low mask value for both receive-interrupt selections, which catches an inverted selection bit.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  // Byte offsets of the register window
  localparam int OFF_MODE = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_CMD  = 'h08;
  localparam int OFF_DATA = 'h0C;
  localparam int OFF_AUX  = 'h10;
  localparam int OFF_INT  = 'h14;
  localparam int OFF_BDH  = 'h18;
  localparam int OFF_BDL  = 'h1C;

  // Field codes of the packed command byte
  localparam logic [1:0] MISC_PTR_CLR = 2'd1;
  localparam logic [1:0] MISC_RX_RST  = 2'd2;
  localparam logic [1:0] MISC_TX_RST  = 2'd3;
  localparam logic [1:0] PATH_ON      = 2'd1;
  localparam logic [1:0] PATH_OFF     = 2'd2;

  typedef struct packed {
    logic mrWr;
    logic ptrClr;
    logic rxReset;
    logic txReset;
    logic txOn;
    logic txOff;
    logic rxOn;
    logic rxOff;
    logic tbWr;
    logic imrWr;
    logic rxPop;
  } ctlStrobes_t;

endpackage

// File: rtl/uart_csr_ctl.sv
module uart_csr_ctl
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [5:0]        cmdBits,
  output ctlStrobes_t       strb
);

  logic wrHit, rdHit, isCmd;
  logic [1:0] miscField, txField, rxField;

  assign wrHit     = busSel && busWe;
  assign rdHit     = busSel && !busWe;
  assign isCmd     = wrHit && (busAddr == ADDR_W'(OFF_CMD));
  assign miscField = cmdBits[5:4];
  assign txField   = cmdBits[3:2];
  assign rxField   = cmdBits[1:0];

  always_comb begin
    strb         = '0;
    strb.mrWr    = wrHit && (busAddr == ADDR_W'(OFF_MODE));
    strb.tbWr    = wrHit && (busAddr == ADDR_W'(OFF_DATA));
    strb.imrWr   = wrHit && (busAddr == ADDR_W'(OFF_INT));
    strb.rxPop   = rdHit && (busAddr == ADDR_W'(OFF_DATA));
    strb.ptrClr  = isCmd && (miscField == MISC_PTR_CLR);
    strb.rxReset = isCmd && (miscField == MISC_RX_RST);
    strb.txReset = isCmd && (miscField == MISC_TX_RST);
    strb.txOn    = isCmd && (txField == PATH_ON);
    strb.txOff   = isCmd && (txField == PATH_OFF);
    strb.rxOn    = isCmd && (rxField == PATH_ON);
    strb.rxOff   = isCmd && (rxField == PATH_OFF);
  end

endmodule

// File: rtl/uart_csr_dp.sv
module uart_csr_dp
  import uart_csr_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 8,
  parameter int          RX_DEPTH = 4,
  parameter logic [7:0]  BAUD_HI  = 8'h12,
  parameter logic [7:0]  BAUD_LO  = 8'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              irq
);

  localparam int CNT_W       = $clog2(RX_DEPTH + 1);
  localparam int RXINT_SEL_B = 6;

  logic [DATA_W-1:0] modeReg [2];
  logic              modePtr;
  logic              txEn, txEmp, rxEn;
  logic [DATA_W-1:0] txHold, imr;
  logic [DATA_W-1:0] rxMem  [RX_DEPTH];
  logic [DATA_W-1:0] rxMemN [RX_DEPTH];
  logic [CNT_W-1:0]  rxCount, wrIdx;
  logic              txEnN, txEmpN, rxEnN, handoff;
  logic              pushOk, popOk, rxNonEmpty, rxFull, rxIntSrc;
  logic [DATA_W-1:0] statusByte, isrByte;

  // Transmit path: misc action first, then transmitter field
  always_comb begin
    txEnN   = txEn;
    txEmpN  = txEmp;
    handoff = 1'b0;
    if (strb.txReset) begin
      txEnN  = 1'b0;
      txEmpN = 1'b1;
    end
    if (strb.txOn) begin
      txEnN = 1'b1;
      if (!txEmpN) begin
        handoff = 1'b1;
        txEmpN  = 1'b1;
      end
    end
    if (strb.txOff) txEnN = 1'b0;
    if (strb.tbWr) begin
      if (txEn) handoff = 1'b1;
      else      txEmpN  = 1'b0;
    end
  end

  always_comb begin
    rxEnN = rxEn;
    if (strb.rxReset) rxEnN = 1'b0;
    if (strb.rxOn)    rxEnN = 1'b1;
    if (strb.rxOff)   rxEnN = 1'b0;
  end

  // Receive FIFO as a shift array, head at index 0
  assign rxNonEmpty = (rxCount != '0);
  assign rxFull     = (rxCount == CNT_W'(RX_DEPTH));
  assign rxReady    = rxEn && !rxFull;
  assign pushOk     = rxValid && rxReady;
  assign popOk      = strb.rxPop && rxNonEmpty;
  assign wrIdx      = rxCount - CNT_W'(popOk);

  always_comb begin
    for (int i = 0; i < RX_DEPTH; i++) rxMemN[i] = rxMem[i];
    if (popOk) begin
      for (int i = 0; i < RX_DEPTH - 1; i++) rxMemN[i] = rxMem[i+1];
      rxMemN[RX_DEPTH-1] = '0;
    end
    for (int i = 0; i < RX_DEPTH; i++)
      if (pushOk && (CNT_W'(i) == wrIdx)) rxMemN[i] = rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg[0] <= '0;
      modeReg[1] <= '0;
      modePtr    <= 1'b0;
      txEn       <= 1'b0;
      txEmp      <= 1'b1;
      rxEn       <= 1'b0;
      txHold     <= '0;
      txValid    <= 1'b0;
      imr        <= '0;
      rxCount    <= '0;
      for (int i = 0; i < RX_DEPTH; i++) rxMem[i] <= '0;
    end else begin
      if (strb.mrWr) modeReg[modePtr] <= busWdata;
      if (strb.ptrClr)    modePtr <= 1'b0;
      else if (strb.mrWr) modePtr <= 1'b1;
      txEn    <= txEnN;
      txEmp   <= txEmpN;
      rxEn    <= rxEnN;
      txValid <= handoff;
      if (strb.tbWr)  txHold <= busWdata;
      if (strb.imrWr) imr    <= busWdata;
      if (strb.rxReset) rxCount <= '0;
      else              rxCount <= rxCount + CNT_W'(pushOk) - CNT_W'(popOk);
      for (int i = 0; i < RX_DEPTH; i++) rxMem[i] <= rxMemN[i];
    end
  end

  assign txData     = txHold;
  assign rxIntSrc   = modeReg[0][RXINT_SEL_B] ? rxFull : rxNonEmpty;
  assign statusByte = DATA_W'({txEmp, txEn, rxFull, rxNonEmpty});
  assign isrByte    = DATA_W'({rxIntSrc, txEn});
  assign irq        = |(isrByte & imr);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFF_MODE): busRdata = modeReg[modePtr];
      ADDR_W'(OFF_STAT): busRdata = statusByte;
      ADDR_W'(OFF_DATA): busRdata = rxNonEmpty ? rxMem[0] : '0;
      ADDR_W'(OFF_INT):  busRdata = isrByte;
      ADDR_W'(OFF_BDH):  busRdata = DATA_W'(BAUD_HI);
      ADDR_W'(OFF_BDL):  busRdata = DATA_W'(BAUD_LO);
      default:           busRdata = '0;
    endcase
  end

  // Pulse only follows a data write or a transmitter enable
  assert_handoff_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(strb.tbWr || strb.txOn));
  assert_mode_ptr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mrWr && !strb.ptrClr) |=> modePtr);
  assert_txoff_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.txOff |=> !txEn);
  assert_txreset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txReset && !strb.txOn) |=> (txEmp && !txEn && !txValid));
  assert_rxreset_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxReset |=> (rxCount == '0));
  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(RX_DEPTH));

endmodule

// File: rtl/uart_csr_ctrl.sv
module uart_csr_ctrl
  import uart_csr_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         DATA_W   = 8,
  parameter int         RX_DEPTH = 4,
  parameter logic [7:0] BAUD_HI  = 8'h12,
  parameter logic [7:0] BAUD_LO  = 8'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [DATA_W-1:0] txData,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              irq
);

  ctlStrobes_t strb;

  uart_csr_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .busSel (busSel),
    .busWe  (busWe),
    .busAddr(busAddr),
    .cmdBits(busWdata[5:0]),
    .strb   (strb)
  );

  uart_csr_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH),
    .BAUD_HI(BAUD_HI), .BAUD_LO(BAUD_LO)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .txValid (txValid),
    .txData  (txData),
    .rxValid (rxValid),
    .rxData  (rxData),
    .rxReady (rxReady),
    .irq     (irq)
  );

endmodule

// File: tb/uart_csr_ctrl_tb.sv
module uart_csr_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWe = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata, txData;
  logic       txValid, rxReady, irq;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;

  int  nChecks = 0, nFails = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  uart_csr_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txValid(txValid), .txData(txData),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic pushRx(input logic [7:0] d, output logic acc);
    @(negedge clk);
    rxValid = 1; rxData = d; acc = rxReady;
    @(negedge clk);
    rxValid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic acc;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txValid", txValid, 0);
    chk("R1 rxReady", rxReady, 0);
    chk("R1 irq", irq, 0);
    busRead(6'h04, rd); chk("R1 status", rd, 8'h08);
    busRead(6'h14, rd); chk("R1 isr", rd, 0);
    busRead(6'h00, rd); chk("R1 mode", rd, 0);

    // R2 mode pointer walk
    busWrite(6'h00, 8'h5A); busRead(6'h00, rd); chk("R2 second after first write", rd, 8'h00);
    busWrite(6'h00, 8'hC3); busRead(6'h00, rd); chk("R2 second written", rd, 8'hC3);
    busWrite(6'h00, 8'h77); busRead(6'h00, rd); chk("R2 pointer sticks", rd, 8'h77);
    busWrite(6'h08, 8'h10); busRead(6'h00, rd); chk("R2 pointer reset", rd, 8'h5A);
    busWrite(6'h00, 8'h00); busWrite(6'h08, 8'h10);

    // R4 R5 R6 transmit paths
    busWrite(6'h08, 8'h04); busRead(6'h04, rd); chk("R6 enabled ready", rd, 8'h0C);
    busWrite(6'h0C, 8'h3C);
    chk("R4 pulse", txValid, 1); chk("R4 data", txData, 8'h3C);
    @(negedge clk); chk("R4 single cycle", txValid, 0);
    busRead(6'h04, rd); chk("R4 empty stays", rd, 8'h0C);
    busWrite(6'h08, 8'h08); busRead(6'h04, rd); chk("R6 disabled", rd, 8'h08);
    busWrite(6'h0C, 8'h99); chk("R4 no pulse disabled", txValid, 0);
    busRead(6'h04, rd); chk("R4 held", rd, 8'h00);
    busWrite(6'h08, 8'h04); chk("R5 pulse on enable", txValid, 1); chk("R5 data", txData, 8'h99);
    busRead(6'h04, rd); chk("R5 status", rd, 8'h0C);
    busWrite(6'h08, 8'h08); busWrite(6'h0C, 8'h55); busWrite(6'h08, 8'h30);
    busRead(6'h04, rd); chk("R7 after tx reset", rd, 8'h08);
    busWrite(6'h08, 8'h04); chk("R7 dropped byte", txValid, 0);

    // R3 R5 R7 R9 command sweep
    for (int st = 0; st < 6; st++) begin
      for (int c = 0; c < 64; c++) begin
        bit tEn0 = (st % 3) == 1;
        bit pend = (st % 3) == 2;
        bit rEn0 = st >= 3;
        bit tEn, emp, rEn, ho;
        int cnt;
        logic [1:0] m, t, r;
        busWrite(6'h08, 8'h30); busWrite(6'h08, 8'h20);
        if (pend) busWrite(6'h0C, 8'hA5);
        if (tEn0) busWrite(6'h08, 8'h04);
        if (rEn0) begin busWrite(6'h08, 8'h01); pushRx(8'h42, acc); end
        m = c[5:4]; t = c[3:2]; r = c[1:0];
        tEn = tEn0; emp = !pend; rEn = rEn0; cnt = rEn0 ? 1 : 0; ho = 0;
        if (m == 2) begin rEn = 0; cnt = 0; end
        if (m == 3) begin tEn = 0; emp = 1; end
        if (t == 1) begin tEn = 1; if (!emp) begin ho = 1; emp = 1; end end
        if (t == 2) tEn = 0;
        if (r == 1) rEn = 1;
        if (r == 2) rEn = 0;
        busWrite(6'h08, {2'(c + st), 6'(c)});
        chk("R5 sweep handoff", txValid, 32'(ho));
        chk("R3 sweep rxReady", rxReady, 32'(rEn));
        busRead(6'h04, rd);
        chk("R3 R7 R9 sweep status", rd, {4'b0, emp, tEn, 1'b0, cnt != 0});
      end
    end

    // R8 FIFO order, full, refuse, empty
    busWrite(6'h08, 8'h20);
    pushRx(8'h61, acc); chk("R8 refused when disabled", acc, 0);
    busWrite(6'h08, 8'h01);
    for (int k = 0; k < 4; k++) begin
      pushRx(8'(8'h10 + k * 8'h11), acc); chk("R8 accept", acc, 1);
    end
    busRead(6'h04, rd); chk("R8 full flags", rd[1:0], 2'b11);
    pushRx(8'hEE, acc); chk("R8 refuse when full", acc, 0);
    for (int k = 0; k < 4; k++) begin
      busRead(6'h0C, rd); chk("R8 order", rd, 8'(8'h10 + k * 8'h11));
    end
    busRead(6'h0C, rd); chk("R8 empty reads zero", rd, 0);
    busRead(6'h04, rd); chk("R8 empty flags", rd[1:0], 2'b00);

    // R10 R11 interrupt sweep
    for (int ms = 0; ms < 2; ms++) begin
      for (int f = 0; f < 3; f++) begin
        int fill = (f == 0) ? 0 : (f == 1) ? 1 : 4;
        bit te = (f != 1);
        bit ri;
        logic [1:0] isrExp;
        busWrite(6'h08, 8'h10); busWrite(6'h00, 8'(ms << 6));
        busWrite(6'h08, 8'h30); busWrite(6'h08, 8'h21);
        if (te) busWrite(6'h08, 8'h04);
        for (int k = 0; k < fill; k++) pushRx(8'(k), acc);
        ri = ms ? (fill == 4) : (fill > 0);
        isrExp = {ri, te};
        for (int im = 0; im < 8; im++) begin
          busWrite(6'h14, 8'(im));
          busRead(6'h14, rd); chk("R10 isr", rd, {6'b0, isrExp});
          chk("R11 irq", irq, 32'(|(isrExp & 2'(im))));
        end
      end
    end

    // R12 fixed and unmapped offsets
    busRead(6'h18, rd); chk("R12 baud hi", rd, 8'h12);
    busRead(6'h1C, rd); chk("R12 baud lo", rd, 8'h34);
    busRead(6'h04, rd);
    busWrite(6'h04, 8'hFF); busWrite(6'h10, 8'hFF);
    begin
      logic [7:0] rd2;
      busRead(6'h04, rd2); chk("R12 status write ignored", rd2, rd);
    end
    busRead(6'h10, rd); chk("R12 aux reads zero", rd, 0);
    busRead(6'h08, rd); chk("R12 cmd reads zero", rd, 0);
    busRead(6'h3C, rd); chk("R12 unmapped", rd, 0);
    busRead(6'h20, rd); chk("R12 unmapped low", rd, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule